// File: doc/BRIEF.md
# Per-Thread Loop Replay Buffer

This block sits after the decoder in a two-thread front end. It records the micro-op words of each hardware thread in that thread's own storage. A short loop is closed by a backward branch whose target tag equals the tag of the first recorded word. When such a loop fits in the storage, the block stops taking new words for that thread and plays the loop back from storage, one word per cycle. While it plays back, it holds a line high that tells the branch predictor for that thread to stop predicting.

Branches are still resolved while a loop plays back. A mispredict reported for a thread ends its playback at once. The storage is then wiped in a single cycle and the thread returns to watching the normal decode stream. The two threads never share storage or state, so one thread leaving playback does not disturb the other.

Top module: `loop_replay_buf`

## Requirements
- R1: After reset, neither thread plays back (`replayValid` low) and neither predictor-suppress line is high.
- R2: A captured word flagged as a backward branch, whose target tag equals the tag of the first captured word of that thread, closes the loop. The body is every captured word up to and including that branch. From the next cycle the thread plays back.
- R3: A body may hold up to 64 words, and a 64-word body plays back. If a 65th word arrives for a thread while 64 words are held, the capture is dropped and that thread never starts playback for it.
- R4: Playback outputs one stored word per cycle. It starts with the first captured word, follows capture order and wraps to the first word after the closing branch.
- R5: For each thread, `suppressPred` is high exactly in the cycles in which that thread plays back.
- R6: A mispredict for a thread that is playing back drops both its outputs low in the next cycle. That cycle is a one-cycle wipe, in which arriving words are ignored. The thread then accepts a new capture.
- R7: A mispredict for a thread that is capturing drops the capture, so no playback follows.
- R8: A backward branch whose target tag does not match the first captured word's tag drops the capture, so no playback follows.
- R9: Words tagged with the other thread's ID are never stored in a thread's buffer, and a mispredict on one thread leaves the other thread's playback unchanged.
- R10: Words arriving for a thread that is playing back are ignored, and the playback sequence goes on unchanged.
- R11: A single word that is a backward branch targeting its own tag forms a one-word loop, which plays back in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A decoded micro-op word is present this cycle |
| inThread | input | TID_W | Thread ID of the incoming word |
| inUop | input | UOP_W | Incoming micro-op word |
| inTag | input | TAG_W | Fetch tag of the incoming word |
| inBackBr | input | 1 | Incoming word is a backward branch |
| inBrTarget | input | TAG_W | Target tag of that branch |
| mispredict | input | NUM_THREADS | Per-thread resolved mispredict |
| replayValid | output | NUM_THREADS | Per-thread playback word is valid |
| replayUop | output | NUM_THREADS*UOP_W | Per-thread playback word, thread t at bits [t*UOP_W +: UOP_W] |
| suppressPred | output | NUM_THREADS | Per-thread request to halt branch prediction |

## Verification
Two kinds of internal fault show up at the ports. A wrong length or read pointer appears on `replayUop` within one loop period: a word repeats, a word is skipped, or the wrap comes early or late. A wrong controller state shows up within one or two cycles, as `replayValid` or `suppressPred` going high when no loop was closed, or staying high after a mispredict. The bench sweeps every body length from 1 to 64 across both threads and predicts each playback word from its index modulo the length. It then drives the 65-word overflow, the non-matching branch, a mispredict during capture and interleaved two-thread traffic, and checks the outputs in every cycle.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CAPTURE, ST_STREAM, ST_FLUSH} lrbState_t;

  typedef struct packed {
    logic capFirst;   // write entry 0 and latch head tag
    logic capNext;    // append at current count
    logic closeLoop;  // fix body length, reset read pointer
    logic advance;    // step read pointer
    logic clear;      // wipe counts
  } lrbStrobe_t;
endpackage

// File: rtl/lrb_store.sv
module lrb_store
  import lrb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int UOP_W = 32,
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  lrbStrobe_t       strb,
  input  logic [UOP_W-1:0] inUop,
  input  logic [TAG_W-1:0] inTag,
  input  logic [TAG_W-1:0] inBrTarget,
  output logic             headHit,
  output logic             selfHit,
  output logic             isFull,
  output logic [UOP_W-1:0] rdUop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [UOP_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] wrCnt;
  logic [CNT_W-1:0] loopLen;
  logic [PTR_W-1:0] rdPtr;
  logic [TAG_W-1:0] headTag;
  logic [PTR_W-1:0] wrIdx;

  assign wrIdx = strb.capFirst ? '0 : wrCnt[PTR_W-1:0];

  always_ff @(posedge clk) begin
    if (strb.capFirst || strb.capNext) mem[wrIdx] <= inUop;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      wrCnt   <= '0;
      loopLen <= '0;
      rdPtr   <= '0;
      headTag <= '0;
    end else begin
      if (strb.capFirst) begin
        wrCnt   <= CNT_W'(1);
        headTag <= inTag;
      end else if (strb.capNext) begin
        wrCnt <= wrCnt + CNT_W'(1);
      end
      if (strb.closeLoop) begin
        loopLen <= strb.capFirst ? CNT_W'(1) : wrCnt + CNT_W'(1);
        rdPtr   <= '0;
      end else if (strb.advance) begin
        rdPtr <= (CNT_W'(rdPtr) + CNT_W'(1) == loopLen) ? '0 : rdPtr + PTR_W'(1);
      end
    end
  end

  assign headHit = (inBrTarget == headTag);
  assign selfHit = (inBrTarget == inTag);
  assign isFull  = (wrCnt == CNT_W'(DEPTH));
  assign rdUop   = mem[rdPtr];

  // R3: capture count never passes the storage depth
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrCnt <= CNT_W'(DEPTH));
  // R4: read pointer stays inside the captured body
  assert_rd_in_body_R4: assert property (@(posedge clk) disable iff (!rstN)
    (loopLen != '0) |-> (CNT_W'(rdPtr) < loopLen));
  // R6: a wipe leaves the buffer empty
  assert_wipe_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (wrCnt == '0 && loopLen == '0));
endmodule

// File: rtl/lrb_ctrl.sv
module lrb_ctrl
  import lrb_pkg::*;
#(
  parameter int TID_W  = 1,
  parameter int THREAD = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [TID_W-1:0] inThread,
  input  logic             inBackBr,
  input  logic             headHit,
  input  logic             selfHit,
  input  logic             isFull,
  input  logic             mispredict,
  output lrbStrobe_t       strb,
  output logic             streaming
);
  lrbState_t state, nextState;
  logic uopHere;

  assign uopHere = inValid && (inThread == TID_W'(THREAD));

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (!mispredict && uopHere) begin
        strb.capFirst = 1'b1;
        if (inBackBr && selfHit) begin
          strb.closeLoop = 1'b1;
          nextState      = ST_STREAM;
        end else begin
          nextState = ST_CAPTURE;
        end
      end
      ST_CAPTURE: if (mispredict) begin
        nextState = ST_FLUSH;
      end else if (uopHere) begin
        if (isFull) begin
          nextState = ST_FLUSH;
        end else begin
          strb.capNext = 1'b1;
          if (inBackBr) begin
            if (headHit) begin
              strb.closeLoop = 1'b1;
              nextState      = ST_STREAM;
            end else begin
              nextState = ST_FLUSH;
            end
          end
        end
      end
      ST_STREAM: if (mispredict) nextState = ST_FLUSH;
                 else strb.advance = 1'b1;
      ST_FLUSH: begin
        strb.clear = 1'b1;
        nextState  = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign streaming = (state == ST_STREAM);

  // R6: mispredict during playback goes to the wipe state
  assert_bail_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STREAM && mispredict) |=> (state == ST_FLUSH));
  // R6: the wipe lasts exactly one cycle
  assert_wipe_once_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FLUSH) |=> (state == ST_IDLE));
  // R3: an over-long body never reaches playback
  assert_no_long_loop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CAPTURE && uopHere && isFull) |=> !streaming);
  // R2: playback starts only right after a word of this thread
  assert_enter_on_branch_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(streaming) |-> $past(uopHere && inBackBr));
  // R7: mispredict during capture never leads into playback
  assert_cap_bail_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CAPTURE && mispredict) |=> !streaming);
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.capFirst, strb.capNext, strb.clear, strb.advance}));
endmodule

// File: rtl/loop_replay_buf.sv
module loop_replay_buf
  import lrb_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int DEPTH       = 64,
  parameter int UOP_W       = 32,
  parameter int TAG_W       = 16,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic [TID_W-1:0]             inThread,
  input  logic [UOP_W-1:0]             inUop,
  input  logic [TAG_W-1:0]             inTag,
  input  logic                         inBackBr,
  input  logic [TAG_W-1:0]             inBrTarget,
  input  logic [NUM_THREADS-1:0]       mispredict,
  output logic [NUM_THREADS-1:0]       replayValid,
  output logic [NUM_THREADS*UOP_W-1:0] replayUop,
  output logic [NUM_THREADS-1:0]       suppressPred
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
    lrbStrobe_t       strb;
    logic             headHit, selfHit, isFull, streaming;
    logic [UOP_W-1:0] rdUop;

    lrb_ctrl #(.TID_W(TID_W), .THREAD(t)) u_ctrl (
      .clk(clk), .rstN(rstN), .inValid(inValid), .inThread(inThread),
      .inBackBr(inBackBr), .headHit(headHit), .selfHit(selfHit),
      .isFull(isFull), .mispredict(mispredict[t]), .strb(strb),
      .streaming(streaming)
    );

    lrb_store #(.DEPTH(DEPTH), .UOP_W(UOP_W), .TAG_W(TAG_W)) u_store (
      .clk(clk), .rstN(rstN), .strb(strb), .inUop(inUop), .inTag(inTag),
      .inBrTarget(inBrTarget), .headHit(headHit), .selfHit(selfHit),
      .isFull(isFull), .rdUop(rdUop)
    );

    assign replayValid[t]               = streaming;
    assign suppressPred[t]              = streaming;
    assign replayUop[t*UOP_W +: UOP_W]  = streaming ? rdUop : '0;
  end
endmodule

// File: tb/sim_loop_replay_buf.sv
module sim_loop_replay_buf;
  localparam int CLK_P = 10;
  localparam int NT = 2;
  localparam int UW = 32;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [0:0] inThread = '0;
  logic [UW-1:0] inUop = '0;
  logic [TW-1:0] inTag = '0;
  logic inBackBr = 1'b0;
  logic [TW-1:0] inBrTarget = '0;
  logic [NT-1:0] mispredict = '0;
  logic [NT-1:0] replayValid, suppressPred;
  logic [NT*UW-1:0] replayUop;

  always #(CLK_P/2) clk = ~clk;

  loop_replay_buf u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inThread(inThread),
    .inUop(inUop), .inTag(inTag), .inBackBr(inBackBr), .inBrTarget(inBrTarget),
    .mispredict(mispredict), .replayValid(replayValid), .replayUop(replayUop),
    .suppressPred(suppressPred)
  );

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;
  string curReq = "R1";
  bit expStream [NT];
  int expLen [NT];
  int expPhase [NT];

  function automatic logic [UW-1:0] mkUop(int t, int l, int i);
    return {8'(t), 8'(l), 16'(i)};
  endfunction
  function automatic logic [TW-1:0] mkTag(int t, int l, int i);
    return TW'((t << 14) | (l << 7) | i);
  endfunction

  task automatic chk(bit ok, string what, logic [UW-1:0] act, logic [UW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  // R5: suppress mirrors playback; R4: word = entry (phase mod length)
  task automatic checkCycle();
    for (int t = 0; t < NT; t++) begin
      chk(replayValid[t] == expStream[t], $sformatf("t%0d valid", t),
          UW'(replayValid[t]), UW'(expStream[t]));
      chk(suppressPred[t] == expStream[t], $sformatf("t%0d R5 suppress", t),
          UW'(suppressPred[t]), UW'(expStream[t]));
      if (expStream[t])
        chk(replayUop[t*UW +: UW] == mkUop(t, expLen[t], expPhase[t]),
            $sformatf("t%0d word", t), replayUop[t*UW +: UW],
            mkUop(t, expLen[t], expPhase[t]));
    end
  endtask

  task automatic step(bit v, int t, int l, int i, bit br, bit match, bit closes,
                      logic [NT-1:0] misp, logic [UW-1:0] word);
    @(negedge clk);
    checkCycle();
    for (int k = 0; k < NT; k++)
      if (expStream[k]) expPhase[k] = (expPhase[k] + 1) % expLen[k];
    inValid    = v;
    inThread   = 1'(t);
    inUop      = word;
    inTag      = mkTag(t, l, i);
    inBackBr   = br;
    inBrTarget = match ? mkTag(t, l, 0) : (mkTag(t, l, 0) ^ TW'(16'h0F0F));
    mispredict = misp;
    for (int k = 0; k < NT; k++) if (misp[k]) expStream[k] = 1'b0;
    if (v && closes) begin
      expStream[t] = 1'b1;
      expLen[t]    = l;
      expPhase[t]  = 0;
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 1, 0, '0, '0);
  endtask

  task automatic sendBody(int t, int l);
    for (int i = 0; i < l; i++)
      step(1, t, l, i, i == l - 1, 1, i == l - 1, '0, mkUop(t, l, i));
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NT; k++) begin
      expStream[k] = 0; expLen[k] = 1; expPhase[k] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    curReq = "R1";
    idle(3);

    // R2 R4 R6 R11: every body length, alternating threads, bail then recapture
    for (int l = 1; l <= 64; l++) begin
      int t = l % 2;
      curReq = (l == 1) ? "R11" : (l == 64) ? "R3" : "R2/R4";
      sendBody(t, l);
      idle(2 * l + 2);
      curReq = "R6";
      step(0, 0, 0, 0, 0, 1, 0, NT'(1 << t), '0);
      step(1, t, 9, 0, 1, 1, 0, '0, mkUop(t, 9, 0)); // arrives in wipe cycle: ignored
      idle(1);
    end

    // R3: 65th word while full drops the capture
    curReq = "R3";
    for (int i = 0; i < 64; i++) step(1, 0, 65, i, 0, 1, 0, '0, mkUop(0, 65, i));
    step(1, 0, 65, 64, 1, 1, 0, '0, mkUop(0, 65, 64));
    idle(4);
    sendBody(0, 2);
    idle(5);
    step(0, 0, 0, 0, 0, 1, 0, 2'b01, '0);
    idle(2);

    // R8: non-matching backward branch
    curReq = "R8";
    step(1, 1, 3, 0, 0, 1, 0, '0, mkUop(1, 3, 0));
    step(1, 1, 3, 1, 0, 1, 0, '0, mkUop(1, 3, 1));
    step(1, 1, 3, 2, 1, 0, 0, '0, mkUop(1, 3, 2));
    idle(4);

    // R7: mispredict during capture
    curReq = "R7";
    step(1, 0, 3, 0, 0, 1, 0, '0, mkUop(0, 3, 0));
    step(1, 0, 3, 1, 0, 1, 0, '0, mkUop(0, 3, 1));
    step(0, 0, 0, 0, 0, 1, 0, 2'b01, '0);
    step(1, 0, 3, 2, 1, 1, 0, '0, mkUop(0, 3, 2));
    idle(4);

    // R9: interleaved capture of two threads, independent bail
    curReq = "R9";
    step(1, 0, 4, 0, 0, 1, 0, '0, mkUop(0, 4, 0));
    step(1, 1, 3, 0, 0, 1, 0, '0, mkUop(1, 3, 0));
    step(1, 0, 4, 1, 0, 1, 0, '0, mkUop(0, 4, 1));
    step(1, 1, 3, 1, 0, 1, 0, '0, mkUop(1, 3, 1));
    step(1, 0, 4, 2, 0, 1, 0, '0, mkUop(0, 4, 2));
    step(1, 1, 3, 2, 1, 1, 1, '0, mkUop(1, 3, 2));
    step(1, 0, 4, 3, 1, 1, 1, '0, mkUop(0, 4, 3));
    // R10: words for a streaming thread are ignored
    curReq = "R10";
    step(1, 1, 99, 0, 0, 1, 0, '0, mkUop(1, 99, 0));
    step(1, 1, 3, 5, 1, 1, 0, '0, mkUop(1, 99, 5));
    step(1, 0, 99, 1, 0, 1, 0, '0, mkUop(0, 99, 1));
    idle(5);
    curReq = "R9";
    step(0, 0, 0, 0, 0, 1, 0, 2'b01, '0);
    idle(6);
    step(0, 0, 0, 0, 0, 1, 0, 2'b10, '0);
    idle(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule